// File: doc/BRIEF.md
# Thread-Partitioned Translation Cache

This block caches virtual-to-physical page translations for a processor core that runs several hardware threads. Storage is split into one private, fully associative partition per thread. Every lookup, insert and single-page removal carries a thread number and only ever touches that thread's partition. The two bulk flushes are the exception: they sweep every partition at once.

Each entry records its own page size as a log2 value, so small and large pages can sit side by side in one partition. A lookup compares only the address bits above that size. Replacement uses least-recent use. A single 32-bit stamp counter, shared by all partitions, hands out the ages. A translation walker outside the block feeds the insert port. The lookup port returns hit or miss and the stored fields one cycle after the request.

Top module: `tlbPartitioned`

## Requirements
- R1: A lookup presented with `lkValid` produces `rspValid` exactly one cycle later, with `rspHit` and, on a hit, the stored physical page, page-size log2 and flags. `rspValid` and `rspHit` are low in every other cycle.
- R2: A lookup searches only the partition named by `lkTid`, so a page inserted under one thread never hits for another thread.
- R3: An entry matches an address when all bits at or above its page-size log2 are equal. One large-page entry therefore covers every offset in its page. The flags are returned as stored, with bit0 writable, bit1 user, bit2 uncacheable, bit3 global, bit4 attribute-table bit and bit5 no-execute.
- R4: An insert whose address already hits in its thread's partition changes nothing. The stored entry keeps its old physical page, and `insExisting` pulses high in the cycle after the insert. A fresh insert leaves `insExisting` low.
- R5: An insert goes into the lowest free slot of its partition. When all `ENTRIES` slots are valid, the valid entry with the oldest stamp is overwritten, and every other entry survives.
- R6: Every insert takes a new stamp from the shared counter. A lookup hit takes a new stamp only when `lkUpdateLru` is high, so a lookup without it does not protect an entry from eviction.
- R7: Invalidate opcode 0 clears every entry in every partition.
- R8: Invalidate opcode 1 clears, in every partition, only the entries whose global flag (bit3) is clear.
- R9: Invalidate opcode 2 uses `invAsn` to pick a partition and removes the entries there that cover `invAddr`. Other partitions are untouched, and a demap that hits nothing changes nothing.
- R10: When an insert and a lookup arrive in the same cycle, the insert is applied first, so a lookup of the page being inserted hits.
- R11: When several entries match a lookup, the lowest-index one supplies the response, and `multiHitErr` goes high and stays high until reset.
- R12: After reset, all partitions are empty, and `rspValid`, `rspHit`, `insExisting` and `multiHitErr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lkValid | input | 1 | Lookup request |
| lkTid | input | TID_W | Thread of the lookup |
| lkAddr | input | ADDR_W | Virtual address to translate |
| lkUpdateLru | input | 1 | Refresh the stamp of the hit entry |
| insValid | input | 1 | Insert request |
| insTid | input | TID_W | Thread of the insert |
| insVpage | input | ADDR_W | Virtual page base |
| insPpage | input | ADDR_W | Physical page base |
| insLogBytes | input | 6 | log2 of the page size |
| insFlags | input | 6 | Attribute flags (see R3) |
| invValid | input | 1 | Invalidate command |
| invOp | input | 2 | 0 all, 1 non-global, 2 single page, 3 none |
| invAsn | input | TID_W | Partition selector for a single-page demap |
| invAddr | input | ADDR_W | Address for a single-page demap |
| rspValid | output | 1 | Lookup response valid |
| rspHit | output | 1 | Lookup hit |
| rspPpage | output | ADDR_W | Physical page base of the hit entry |
| rspLogBytes | output | 6 | Page-size log2 of the hit entry |
| rspFlags | output | 6 | Flags of the hit entry |
| insExisting | output | 1 | The previous insert found its page already present |
| multiHitErr | output | 1 | Sticky multiple-match error |

## Verification
On every cycle the assertions check the following. The response comes exactly one cycle after its request, and a hit is never flagged without a response. The multi-hit error never drops once set. A freshly written slot is valid on the next cycle. A full flush leaves no valid entry. The stamp counter holds still when neither an insert nor a lookup is present. Only the bench scenarios can show the rest:
- which entry actually gets evicted,
- whether a lookup without the update flag really leaves an entry unprotected,
- partition isolation,
- that a large page covers its whole range,
- that global entries survive the selective flush.

// File: rtl/tlbPkg.sv
package tlbPkg;
  localparam int LOG_W       = 6;
  localparam int FLAG_W      = 6;
  localparam int FLAG_GLOBAL = 3;
  localparam int STAMP_W     = 32;
  localparam int IDX_MAX     = 16;

  typedef enum logic [1:0] {
    INV_ALL       = 2'd0,
    INV_NONGLOBAL = 2'd1,
    INV_PAGE      = 2'd2,
    INV_NONE      = 2'd3
  } invOp_e;

  // Strobes from control to datapath: slot write and clears.
  typedef struct packed {
    logic               wrEn;
    logic [IDX_MAX-1:0] wrIdx;
    logic [STAMP_W-1:0] wrStamp;
    logic               clrAll;
    logic               clrNonGlobal;
    logic               demapEn;
  } writeStrb_t;

  // Strobe from control to datapath: stamp refresh on a lookup hit.
  typedef struct packed {
    logic               refEn;
    logic [IDX_MAX-1:0] refIdx;
    logic [STAMP_W-1:0] refStamp;
  } touchStrb_t;
endpackage

// File: rtl/tlbDatapath.sv
module tlbDatapath import tlbPkg::*; #(
  parameter  int ENTRIES = 64,
  parameter  int THREADS = 16,
  parameter  int ADDR_W  = 32,
  localparam int TID_W   = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  writeStrb_t        wStrb,
  input  touchStrb_t        tStrb,
  input  logic              lkValid,
  input  logic [TID_W-1:0]  lkTid,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic [TID_W-1:0]  insTid,
  input  logic [ADDR_W-1:0] insVpage,
  input  logic [ADDR_W-1:0] insPpage,
  input  logic [LOG_W-1:0]  insLogBytes,
  input  logic [FLAG_W-1:0] insFlags,
  input  logic [TID_W-1:0]  invAsn,
  input  logic [ADDR_W-1:0] invAddr,
  output logic              lkHit,
  output logic [IDX_W-1:0]  lkIdx,
  output logic              lkMulti,
  output logic              insPresent,
  output logic [IDX_W-1:0]  allocIdx,
  output logic [ADDR_W-1:0] rspPpage,
  output logic [LOG_W-1:0]  rspLogBytes,
  output logic [FLAG_W-1:0] rspFlags
);
  logic [THREADS-1:0][ENTRIES-1:0] validQ;
  logic [ADDR_W-1:0]  vpageQ [THREADS][ENTRIES];
  logic [ADDR_W-1:0]  ppageQ [THREADS][ENTRIES];
  logic [LOG_W-1:0]   logQ   [THREADS][ENTRIES];
  logic [FLAG_W-1:0]  flagsQ [THREADS][ENTRIES];
  logic [STAMP_W-1:0] stampQ [THREADS][ENTRIES];

  function automatic logic [ADDR_W-1:0] pageMask(input logic [LOG_W-1:0] lb);
    logic [ADDR_W-1:0] m;
    m = '1;
    if (int'(lb) >= ADDR_W) m = '0;
    else m = m << lb;
    return m;
  endfunction

  function automatic logic samePage(input logic [ADDR_W-1:0] a,
                                    input logic [ADDR_W-1:0] v,
                                    input logic [LOG_W-1:0] lb);
    return ((a ^ v) & pageMask(lb)) == '0;
  endfunction

  logic [IDX_W-1:0] wrIdx, refIdx;
  assign wrIdx  = wStrb.wrIdx[IDX_W-1:0];
  assign refIdx = tStrb.refIdx[IDX_W-1:0];

  // Insert-before-lookup: the slot being written is seen with its new contents.
  logic bypass;
  assign bypass = wStrb.wrEn && (lkTid == insTid);

  logic [ENTRIES-1:0] lkMatch;
  always_comb begin : lkSearch
    for (int e = 0; e < ENTRIES; e++) begin
      if (bypass && wrIdx == IDX_W'(e))
        lkMatch[e] = samePage(lkAddr, insVpage, insLogBytes);
      else
        lkMatch[e] = validQ[lkTid][e] &&
                     samePage(lkAddr, vpageQ[lkTid][e], logQ[lkTid][e]);
    end
  end

  always_comb begin : lkPick
    lkIdx = '0;
    for (int e = ENTRIES - 1; e >= 0; e--)
      if (lkMatch[e]) lkIdx = IDX_W'(e);
  end

  assign lkHit   = |lkMatch;
  assign lkMulti = $countones(lkMatch) > 1;

  // Insert side: presence check, first free slot, oldest stamp.
  logic               hasFree;
  logic [IDX_W-1:0]   freeIdx, lruIdx;
  logic [STAMP_W-1:0] lruStamp;
  logic               lruSeen;
  always_comb begin : insSearch
    insPresent = 1'b0;
    hasFree    = 1'b0;
    freeIdx    = '0;
    lruIdx     = '0;
    lruStamp   = '0;
    lruSeen    = 1'b0;
    for (int e = ENTRIES - 1; e >= 0; e--)
      if (!validQ[insTid][e]) begin
        hasFree = 1'b1;
        freeIdx = IDX_W'(e);
      end
    for (int e = 0; e < ENTRIES; e++) begin
      if (validQ[insTid][e] &&
          samePage(insVpage, vpageQ[insTid][e], logQ[insTid][e]))
        insPresent = 1'b1;
      if (validQ[insTid][e] && (!lruSeen || stampQ[insTid][e] < lruStamp)) begin
        lruSeen  = 1'b1;
        lruStamp = stampQ[insTid][e];
        lruIdx   = IDX_W'(e);
      end
    end
  end

  assign allocIdx = hasFree ? freeIdx : lruIdx;

  logic [ENTRIES-1:0] dmMatch;
  always_comb begin : dmSearch
    for (int e = 0; e < ENTRIES; e++)
      dmMatch[e] = validQ[invAsn][e] &&
                   samePage(invAddr, vpageQ[invAsn][e], logQ[invAsn][e]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
    end else begin
      if (wStrb.wrEn) validQ[insTid][wrIdx] <= 1'b1;
      for (int t = 0; t < THREADS; t++)
        for (int e = 0; e < ENTRIES; e++)
          if (wStrb.clrAll ||
              (wStrb.clrNonGlobal && !flagsQ[t][e][FLAG_GLOBAL]) ||
              (wStrb.demapEn && TID_W'(t) == invAsn && dmMatch[e]))
            validQ[t][e] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wStrb.wrEn) begin
      vpageQ[insTid][wrIdx] <= insVpage & pageMask(insLogBytes);
      ppageQ[insTid][wrIdx] <= insPpage & pageMask(insLogBytes);
      logQ[insTid][wrIdx]   <= insLogBytes;
      flagsQ[insTid][wrIdx] <= insFlags;
      stampQ[insTid][wrIdx] <= wStrb.wrStamp;
    end
    if (tStrb.refEn) stampQ[lkTid][refIdx] <= tStrb.refStamp;
    if (lkValid) begin
      if (bypass && lkIdx == wrIdx) begin
        rspPpage    <= insPpage & pageMask(insLogBytes);
        rspLogBytes <= insLogBytes;
        rspFlags    <= insFlags;
      end else begin
        rspPpage    <= ppageQ[lkTid][lkIdx];
        rspLogBytes <= logQ[lkTid][lkIdx];
        rspFlags    <= flagsQ[lkTid][lkIdx];
      end
    end
  end

  assert_alloc_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wStrb.wrEn && !wStrb.clrAll && !wStrb.clrNonGlobal && !wStrb.demapEn)
      |=> validQ[$past(insTid)][$past(wrIdx)]);

  assert_flush_empty_R7: assert property (@(posedge clk) disable iff (!rstN)
    wStrb.clrAll |=> (validQ == '0));
endmodule

// File: rtl/tlbControl.sv
module tlbControl import tlbPkg::*; #(
  parameter  int ENTRIES = 64,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lkValid,
  input  logic             lkUpdateLru,
  input  logic             insValid,
  input  logic             invValid,
  input  logic [1:0]       invOp,
  input  logic             lkHit,
  input  logic [IDX_W-1:0] lkIdx,
  input  logic             lkMulti,
  input  logic             insPresent,
  input  logic [IDX_W-1:0] allocIdx,
  output writeStrb_t       wStrb,
  output touchStrb_t       tStrb,
  output logic             rspValid,
  output logic             rspHit,
  output logic             insExisting,
  output logic             multiHitErr
);
  logic [STAMP_W-1:0] seqQ;
  invOp_e             op;
  assign op = invOp_e'(invOp);

  always_comb begin : writeSide
    wStrb              = '0;
    wStrb.wrEn         = insValid && !insPresent;
    wStrb.wrIdx        = IDX_MAX'(allocIdx);
    wStrb.wrStamp      = seqQ;
    wStrb.clrAll       = invValid && (op == INV_ALL);
    wStrb.clrNonGlobal = invValid && (op == INV_NONGLOBAL);
    wStrb.demapEn      = invValid && (op == INV_PAGE);
  end

  always_comb begin : touchSide
    tStrb          = '0;
    tStrb.refEn    = lkValid && lkUpdateLru && lkHit;
    tStrb.refIdx   = IDX_MAX'(lkIdx);
    tStrb.refStamp = seqQ + STAMP_W'(wStrb.wrEn);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqQ        <= '0;
      rspValid    <= 1'b0;
      rspHit      <= 1'b0;
      insExisting <= 1'b0;
      multiHitErr <= 1'b0;
    end else begin
      seqQ        <= seqQ + STAMP_W'(wStrb.wrEn) + STAMP_W'(tStrb.refEn);
      rspValid    <= lkValid;
      rspHit      <= lkValid && lkHit;
      insExisting <= insValid && insPresent;
      if (lkValid && lkMulti) multiHitErr <= 1'b1;
    end
  end

  assert_rsp_timing_R1: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (rspValid == $past(lkValid)));

  assert_hit_has_rsp_R1: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> rspValid);

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    multiHitErr |=> multiHitErr);

  assert_stamp_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!lkValid && !insValid) |=> $stable(seqQ));
endmodule

// File: rtl/tlbPartitioned.sv
module tlbPartitioned import tlbPkg::*; #(
  parameter  int ENTRIES = 64,
  parameter  int THREADS = 16,
  parameter  int ADDR_W  = 32,
  localparam int TID_W   = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lkValid,
  input  logic [TID_W-1:0]  lkTid,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic              lkUpdateLru,
  input  logic              insValid,
  input  logic [TID_W-1:0]  insTid,
  input  logic [ADDR_W-1:0] insVpage,
  input  logic [ADDR_W-1:0] insPpage,
  input  logic [5:0]        insLogBytes,
  input  logic [5:0]        insFlags,
  input  logic              invValid,
  input  logic [1:0]        invOp,
  input  logic [TID_W-1:0]  invAsn,
  input  logic [ADDR_W-1:0] invAddr,
  output logic              rspValid,
  output logic              rspHit,
  output logic [ADDR_W-1:0] rspPpage,
  output logic [5:0]        rspLogBytes,
  output logic [5:0]        rspFlags,
  output logic              insExisting,
  output logic              multiHitErr
);
  if (ENTRIES < 1 || IDX_W > IDX_MAX) begin : gBadSize
    $error("partition size must be between 1 and 2**IDX_MAX");
  end

  writeStrb_t       wStrb;
  touchStrb_t       tStrb;
  logic             lkHit, lkMulti, insPresent;
  logic [IDX_W-1:0] lkIdx, allocIdx;

  tlbControl #(.ENTRIES(ENTRIES)) uCtrl (
    .clk(clk), .rstN(rstN),
    .lkValid(lkValid), .lkUpdateLru(lkUpdateLru),
    .insValid(insValid), .invValid(invValid), .invOp(invOp),
    .lkHit(lkHit), .lkIdx(lkIdx), .lkMulti(lkMulti),
    .insPresent(insPresent), .allocIdx(allocIdx),
    .wStrb(wStrb), .tStrb(tStrb),
    .rspValid(rspValid), .rspHit(rspHit),
    .insExisting(insExisting), .multiHitErr(multiHitErr)
  );

  tlbDatapath #(.ENTRIES(ENTRIES), .THREADS(THREADS), .ADDR_W(ADDR_W)) uData (
    .clk(clk), .rstN(rstN),
    .wStrb(wStrb), .tStrb(tStrb),
    .lkValid(lkValid), .lkTid(lkTid), .lkAddr(lkAddr),
    .insTid(insTid), .insVpage(insVpage), .insPpage(insPpage),
    .insLogBytes(insLogBytes), .insFlags(insFlags),
    .invAsn(invAsn), .invAddr(invAddr),
    .lkHit(lkHit), .lkIdx(lkIdx), .lkMulti(lkMulti),
    .insPresent(insPresent), .allocIdx(allocIdx),
    .rspPpage(rspPpage), .rspLogBytes(rspLogBytes), .rspFlags(rspFlags)
  );
endmodule

// File: tb/sim_tlbPartitioned.sv
module sim_tlbPartitioned;
  localparam int ENTRIES = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lkValid = 0, lkUpdateLru = 0, insValid = 0, invValid = 0;
  logic [3:0]  lkTid = 0, insTid = 0, invAsn = 0;
  logic [31:0] lkAddr = 0, insVpage = 0, insPpage = 0, invAddr = 0;
  logic [5:0]  insLogBytes = 0, insFlags = 0;
  logic [1:0]  invOp = 0;
  logic        rspValid, rspHit, insExisting, multiHitErr;
  logic [31:0] rspPpage;
  logic [5:0]  rspLogBytes, rspFlags;

  int nChecks = 0;
  int nErrs   = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  tlbPartitioned u0 (
    .clk(clk), .rstN(rstN),
    .lkValid(lkValid), .lkTid(lkTid), .lkAddr(lkAddr), .lkUpdateLru(lkUpdateLru),
    .insValid(insValid), .insTid(insTid), .insVpage(insVpage), .insPpage(insPpage),
    .insLogBytes(insLogBytes), .insFlags(insFlags),
    .invValid(invValid), .invOp(invOp), .invAsn(invAsn), .invAddr(invAddr),
    .rspValid(rspValid), .rspHit(rspHit), .rspPpage(rspPpage),
    .rspLogBytes(rspLogBytes), .rspFlags(rspFlags),
    .insExisting(insExisting), .multiHitErr(multiHitErr)
  );

  typedef struct packed {
    logic        isIns;
    logic [3:0]  tid;
    logic [31:0] va;
    logic [31:0] pa;
    logic [5:0]  lb;
    logic        expHit;
    logic [31:0] expPa;
  } vec_t;

  // Inserts: expHit is the expected insExisting. Lookups: expected hit and page.
  localparam vec_t VECS [11] = '{
    '{1'b1, 4'd0, 32'h0000_1000, 32'h0008_0000, 6'd12, 1'b0, 32'h0},
    '{1'b1, 4'd1, 32'h0000_2000, 32'h0009_0000, 6'd12, 1'b0, 32'h0},
    '{1'b0, 4'd0, 32'h0000_1ABC, 32'h0,         6'd0,  1'b1, 32'h0008_0000},
    '{1'b0, 4'd1, 32'h0000_1000, 32'h0,         6'd0,  1'b0, 32'h0},
    '{1'b0, 4'd0, 32'h0000_2000, 32'h0,         6'd0,  1'b0, 32'h0},
    '{1'b1, 4'd0, 32'h0040_0000, 32'h00C0_0000, 6'd22, 1'b0, 32'h0},
    '{1'b0, 4'd0, 32'h007F_FFFC, 32'h0,         6'd0,  1'b1, 32'h00C0_0000},
    '{1'b0, 4'd0, 32'h0080_0000, 32'h0,         6'd0,  1'b0, 32'h0},
    '{1'b0, 4'd1, 32'h0000_2FFF, 32'h0,         6'd0,  1'b1, 32'h0009_0000},
    '{1'b1, 4'd0, 32'h0000_1000, 32'h0000_0000, 6'd12, 1'b1, 32'h0},
    '{1'b0, 4'd0, 32'h0000_1000, 32'h0,         6'd0,  1'b1, 32'h0008_0000}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  endtask

  task automatic insert(input logic [3:0] t, input logic [31:0] va, input logic [31:0] pa,
                        input logic [5:0] lb, input logic [5:0] fl);
    @(negedge clk);
    insValid = 1; insTid = t; insVpage = va; insPpage = pa; insLogBytes = lb; insFlags = fl;
    @(negedge clk);
    insValid = 0;
  endtask

  task automatic lookup(input logic [3:0] t, input logic [31:0] va, input logic upd);
    @(negedge clk);
    lkValid = 1; lkTid = t; lkAddr = va; lkUpdateLru = upd;
    @(negedge clk);
    lkValid = 0; lkUpdateLru = 0;
  endtask

  task automatic expectLk(input string req, input logic [3:0] t, input logic [31:0] va,
                          input logic upd, input logic eh, input logic [31:0] ep);
    lookup(t, va, upd);
    if (eh) chk(req, {31'd0, rspValid, rspHit, rspPpage}, {31'd0, 1'b1, 1'b1, ep});
    else    chk(req, {62'd0, rspValid, rspHit}, {62'd0, 1'b1, 1'b0});
  endtask

  task automatic invalidate(input logic [1:0] op, input logic [3:0] asn, input logic [31:0] a);
    @(negedge clk);
    invValid = 1; invOp = op; invAsn = asn; invAddr = a;
    @(negedge clk);
    invValid = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nErrs++;
      $display("FAIL watchdog all requirements actual=timeout expected=finished");
      summary();
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R12: reset state
    chk("R12 outputs", {60'd0, rspValid, rspHit, insExisting, multiHitErr}, 64'd0);
    expectLk("R12 empty after reset", 4'd0, 32'h0000_1000, 1'b0, 1'b0, 32'h0);

    // Vector table: R1 R2 R3 R4
    for (int i = 0; i < 11; i++) begin
      if (VECS[i].isIns) begin
        insert(VECS[i].tid, VECS[i].va, VECS[i].pa, VECS[i].lb, 6'd0);
        chk("R4 insExisting", {63'd0, insExisting}, {63'd0, VECS[i].expHit});
      end else begin
        expectLk("R1 R2 R3 table lookup", VECS[i].tid, VECS[i].va, 1'b0,
                 VECS[i].expHit, VECS[i].expPa);
      end
    end
    @(negedge clk);
    chk("R1 no response when idle", {62'd0, rspValid, rspHit}, 64'd0);

    // R10: insert and lookup of the same page in one cycle
    @(negedge clk);
    insValid = 1; insTid = 4'd8; insVpage = 32'h0000_5000; insPpage = 32'h00A0_0000;
    insLogBytes = 6'd12; insFlags = 6'd0;
    lkValid = 1; lkTid = 4'd8; lkAddr = 32'h0000_5010; lkUpdateLru = 1;
    @(negedge clk);
    insValid = 0; lkValid = 0; lkUpdateLru = 0;
    chk("R10 insert before lookup", {31'd0, rspValid, rspHit, rspPpage},
        {31'd0, 1'b1, 1'b1, 32'h00A0_0000});

    // R5 R6: fill partition 2, then evict
    for (int i = 0; i < ENTRIES; i++)
      insert(4'd2, 32'((i + 1) << 12), 32'h0100_0000 + 32'(i << 12), 6'd12, 6'd0);
    expectLk("R6 refresh page0", 4'd2, 32'h0000_1000, 1'b1, 1'b1, 32'h0100_0000);
    expectLk("R6 peek page2",    4'd2, 32'h0000_3000, 1'b0, 1'b1, 32'h0100_2000);
    insert(4'd2, 32'h0010_0000, 32'h0200_0000, 6'd12, 6'd0);
    expectLk("R5 oldest evicted", 4'd2, 32'h0000_2000, 1'b0, 1'b0, 32'h0);
    expectLk("R6 refreshed kept", 4'd2, 32'h0000_1000, 1'b0, 1'b1, 32'h0100_0000);
    expectLk("R5 new page hit",   4'd2, 32'h0010_0000, 1'b0, 1'b1, 32'h0200_0000);
    insert(4'd2, 32'h0020_0000, 32'h0300_0000, 6'd12, 6'd0);
    expectLk("R6 peek does not protect", 4'd2, 32'h0000_3000, 1'b0, 1'b0, 32'h0);
    expectLk("R5 neighbour survives",    4'd2, 32'h0000_4000, 1'b0, 1'b1, 32'h0100_3000);

    // R8: non-global flush
    insert(4'd3, 32'h0000_7000, 32'h0070_0000, 6'd12, 6'b001000);
    insert(4'd4, 32'h0000_7000, 32'h0071_0000, 6'd12, 6'b000000);
    insert(4'd3, 32'h0000_8000, 32'h0072_0000, 6'd12, 6'b000111);
    invalidate(2'd1, 4'd0, 32'h0);
    expectLk("R8 global kept",       4'd3, 32'h0000_7000, 1'b0, 1'b1, 32'h0070_0000);
    expectLk("R8 other thread gone", 4'd4, 32'h0000_7000, 1'b0, 1'b0, 32'h0);
    expectLk("R8 non-global gone",   4'd3, 32'h0000_8000, 1'b0, 1'b0, 32'h0);
    expectLk("R8 thread 2 gone",     4'd2, 32'h0000_1000, 1'b0, 1'b0, 32'h0);

    // R7: full flush
    invalidate(2'd0, 4'd0, 32'h0);
    expectLk("R7 global also gone", 4'd3, 32'h0000_7000, 1'b0, 1'b0, 32'h0);

    // R9: single-page demap
    insert(4'd5, 32'h0000_9000, 32'h0090_0000, 6'd12, 6'd0);
    insert(4'd6, 32'h0000_9000, 32'h0091_0000, 6'd12, 6'd0);
    invalidate(2'd2, 4'd5, 32'h0000_9ABC);
    expectLk("R9 demapped",     4'd5, 32'h0000_9000, 1'b0, 1'b0, 32'h0);
    expectLk("R9 other thread", 4'd6, 32'h0000_9000, 1'b0, 1'b1, 32'h0091_0000);
    invalidate(2'd2, 4'd6, 32'h0000_A000);
    expectLk("R9 miss is no-op", 4'd6, 32'h0000_9000, 1'b0, 1'b1, 32'h0091_0000);

    // R3: flags and size returned
    insert(4'd9, 32'h0003_0000, 32'h00F3_0000, 6'd16, 6'b101101);
    lookup(4'd9, 32'h0003_FFFF, 1'b0);
    chk("R3 fields", {44'd0, rspHit, rspPpage[18:0]} , {44'd0, 1'b1, 19'h3_0000});
    chk("R3 size and flags", {52'd0, rspLogBytes, rspFlags}, {52'd0, 6'd16, 6'b101101});

    // R11: overlapping pages
    chk("R11 clear before", {63'd0, multiHitErr}, 64'd0);
    insert(4'd7, 32'h0020_1000, 32'h00AA_A000, 6'd12, 6'd0);
    insert(4'd7, 32'h0020_0000, 32'h00E0_0000, 6'd21, 6'd0);
    chk("R11 large page allocated", {63'd0, insExisting}, 64'd0);
    expectLk("R11 lowest index wins", 4'd7, 32'h0020_1008, 1'b0, 1'b1, 32'h00AA_A000);
    chk("R11 error set", {63'd0, multiHitErr}, 64'd1);
    expectLk("R11 single hit", 4'd7, 32'h0030_0000, 1'b0, 1'b1, 32'h00E0_0000);
    chk("R11 error sticky", {63'd0, multiHitErr}, 64'd1);

    done = 1;
    summary();
  end
endmodule